// File: doc/BRIEF.md
# Interrupt-Driven LED Matrix Scanner

This block drives a multiplexed LED matrix whose column (cathode) pattern is refreshed by a processor in response to a periodic interrupt. A single timing bit taken from the video line counter is watched for falling edges; each such edge raises an active-low interrupt request and at the same clock edge blanks the column latch, so no LED stays lit while the processor changes columns. The timing bit is chosen so that it falls eight times per frame.

The processor answers the request by writing a four-bit column pattern through a column write strobe. That one write loads the column latch and withdraws the request. A second write strobe loads the row (anode) register, which is independent of the interrupt. An LED is lit only where both its row and its column line are driven. The block also provides the full lit/unlit map of the matrix.

Top module: `led_scan_ctrl`

## Requirements
- R1: While reset is low and after it, until the first event, `irq_n` is 1 and `anode`, `cathode` and `lit` are all zero.
- R2: A falling edge of `line_bit`, meaning 1 sampled at one rising clock edge and 0 at the next, drives `irq_n` to 0 from that second edge on; a rising edge or a steady level of `line_bit` does not assert `irq_n`.
- R3: The clock edge that asserts the request also clears `cathode` to zero, and `cathode` stays zero for as long as `irq_n` is 0.
- R4: A column write (`cath_wr` high at a clock edge, no falling edge of `line_bit` at that edge) loads `wr_data` bits 3 to 0 into `cathode`; higher data bits are ignored.
- R5: The same column write returns `irq_n` to 1 at that clock edge.
- R6: Further falling edges while a request is pending keep `irq_n` at 0; requests are not counted, so a single column write releases it.
- R7: When a falling edge of `line_bit` and a column write meet at the same clock edge, the edge wins: `irq_n` becomes 0 and `cathode` becomes zero.
- R8: A row write (`anode_wr` high at a clock edge) loads `wr_data` into `anode` and changes neither `irq_n` nor `cathode`.
- R9: `lit[a*4+c]` is 1 exactly when `anode[a]` and `cathode[c]` are both 1.
- R10: Without a column write or a falling edge of `line_bit`, `cathode` and `irq_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 1 | Timing bit from the video line counter |
| cath_wr | input | 1 | Column latch write strobe, also acknowledges the request |
| anode_wr | input | 1 | Row register write strobe |
| wr_data | input | 8 | Processor write data |
| irq_n | output | 1 | Active-low interrupt request |
| anode | output | 8 | Row drive lines |
| cathode | output | 4 | Column drive lines |
| lit | output | 32 | Lit map, index row*4+column |

## Verification
The checker assumes `line_bit` and the strobes are synchronous to `clk` and held stable around each rising edge, since the edge detector samples the timing bit only once per clock. Its edge-based properties are enabled only from the second clock after reset, because the detector's history is cleared by reset and only then matches the port's past value. The bench changes every input half a period away from the rising edge, keeps `line_bit` high across reset release, and raises and lowers it in separate cycles so that every falling edge it creates is one the requirements define.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    // Request state of the interrupt flip-flop
    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_e;

    localparam int unsigned LSC_CATH_W  = 4;
    localparam int unsigned LSC_ANODE_W = 8;
endpackage

// File: rtl/lsc_edge.sv
module lsc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        fall_o = prev_q & ~level_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/lsc_latch.sv
module lsc_latch
    import lsc_pkg::*;
#(
    parameter int unsigned CATH_W  = LSC_CATH_W,
    parameter int unsigned ANODE_W = LSC_ANODE_W,
    parameter int unsigned DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall_i,
    input  logic               cath_wr_i,
    input  logic               anode_wr_i,
    input  logic [DATA_W-1:0]  data_i,
    output req_e               req_o,
    output logic [CATH_W-1:0]  cath_o,
    output logic [ANODE_W-1:0] anode_o
);
    typedef struct packed {
        req_e               req;
        logic [CATH_W-1:0]  cath;
        logic [ANODE_W-1:0] anode;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (anode_wr_i) st_d.anode = data_i[ANODE_W-1:0];
        // The timing edge outranks the acknowledging write
        if (fall_i) begin
            st_d.req  = REQ_PEND;
            st_d.cath = '0;
        end else if (cath_wr_i) begin
            st_d.req  = REQ_IDLE;
            st_d.cath = data_i[CATH_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.req   <= REQ_IDLE;
            st_q.cath  <= '0;
            st_q.anode <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        req_o   = st_q.req;
        cath_o  = st_q.cath;
        anode_o = st_q.anode;
    end
endmodule

// File: rtl/lsc_matrix.sv
module lsc_matrix #(
    parameter int unsigned CATH_W  = 4,
    parameter int unsigned ANODE_W = 8,
    localparam int unsigned CELLS  = CATH_W * ANODE_W
) (
    input  logic [ANODE_W-1:0] anode_i,
    input  logic [CATH_W-1:0]  cath_i,
    output logic [CELLS-1:0]   lit_o
);
    for (genvar a = 0; a < ANODE_W; a++) begin : g_row
        for (genvar c = 0; c < CATH_W; c++) begin : g_col
            assign lit_o[a*CATH_W + c] = anode_i[a] & cath_i[c];
        end
    end
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
    import lsc_pkg::*;
#(
    parameter int unsigned CATH_W  = LSC_CATH_W,
    parameter int unsigned ANODE_W = LSC_ANODE_W,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned CELLS  = CATH_W * ANODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_bit,
    input  logic               cath_wr,
    input  logic               anode_wr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               irq_n,
    output logic [ANODE_W-1:0] anode,
    output logic [CATH_W-1:0]  cathode,
    output logic [CELLS-1:0]   lit
);
    logic fall;
    req_e req;

    lsc_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(line_bit),
        .fall_o (fall)
    );

    lsc_latch #(
        .CATH_W (CATH_W),
        .ANODE_W(ANODE_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .cath_wr_i (cath_wr),
        .anode_wr_i(anode_wr),
        .data_i    (wr_data),
        .req_o     (req),
        .cath_o    (cathode),
        .anode_o   (anode)
    );

    lsc_matrix #(
        .CATH_W (CATH_W),
        .ANODE_W(ANODE_W)
    ) u_matrix (
        .anode_i(anode),
        .cath_i (cathode),
        .lit_o  (lit)
    );

    assign irq_n = (req != REQ_PEND);
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int unsigned CATH_W  = 4,
    parameter int unsigned ANODE_W = 8,
    parameter int unsigned DATA_W  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        line_bit,
    input logic                        cath_wr,
    input logic                        anode_wr,
    input logic [DATA_W-1:0]           wr_data,
    input logic                        irq_n,
    input logic [ANODE_W-1:0]          anode,
    input logic [CATH_W-1:0]           cathode,
    input logic [CATH_W*ANODE_W-1:0]   lit
);
    logic up_q;
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    AST_EDGE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && $past(line_bit) && !line_bit) |=> (!irq_n && cathode == '0)); // R2
    AST_PEND_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (cathode == '0 && lit == '0)); // R3
    AST_WRITE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cath_wr && !(up_q && $past(line_bit) && !line_bit))
        |=> (irq_n && cathode == $past(wr_data[CATH_W-1:0]))); // R5
    AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        anode_wr |=> (anode == $past(wr_data[ANODE_W-1:0]))); // R8
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !cath_wr && !($past(line_bit) && !line_bit))
        |=> ($stable(cathode) && $stable(irq_n))); // R10
endmodule

bind led_scan_ctrl lsc_checker #(
    .CATH_W (CATH_W),
    .ANODE_W(ANODE_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_bit(line_bit),
    .cath_wr (cath_wr),
    .anode_wr(anode_wr),
    .wr_data (wr_data),
    .irq_n   (irq_n),
    .anode   (anode),
    .cathode (cathode),
    .lit     (lit)
);

// File: tb/led_scan_ctrl_test.sv
module led_scan_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_bit = 1'b1;
    logic        cath_wr = 1'b0;
    logic        anode_wr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        irq_n;
    logic [7:0]  anode;
    logic [3:0]  cathode;
    logic [31:0] lit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .cath_wr(cath_wr),
        .anode_wr(anode_wr), .wr_data(wr_data), .irq_n(irq_n),
        .anode(anode), .cathode(cathode), .lit(lit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then back to the falling edge for sampling and driving
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_col(input logic [7:0] d);
        cath_wr = 1'b1; wr_data = d;
        cycle();
        cath_wr = 1'b0;
    endtask

    task automatic wr_row(input logic [7:0] d);
        anode_wr = 1'b1; wr_data = d;
        cycle();
        anode_wr = 1'b0;
    endtask

    task automatic strobe_fall();
        line_bit = 1'b0;
        cycle();
    endtask

    task automatic strobe_rise();
        line_bit = 1'b1;
        cycle();
    endtask

    function automatic logic [31:0] map(input logic [7:0] a, input logic [3:0] c);
        logic [31:0] m = '0;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 4; j++)
                m[i*4+j] = a[i] & c[j];
        return m;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        cycle(); cycle();
        check("R1 irq_n in reset", irq_n, 1);
        check("R1 cathode in reset", cathode, 0);
        rst_n = 1'b1;
        cycle();
        check("R1 irq_n after reset", irq_n, 1);
        check("R1 anode after reset", anode, 0);
        check("R1 lit after reset", lit, 0);
    endtask

    task automatic t_row_col();
        wr_row(8'hA5);
        check("R8 anode loaded", anode, 8'hA5);
        check("R8 irq untouched", irq_n, 1);
        check("R8 cathode untouched", cathode, 0);
        wr_col(8'hF6);
        check("R4 cathode low nibble", cathode, 4'h6);
        check("R9 lit map", lit, map(8'hA5, 4'h6));
        cycle(); cycle();
        check("R10 cathode holds", cathode, 4'h6);
        check("R10 irq holds", irq_n, 1);
    endtask

    task automatic t_edge_ack();
        strobe_rise();
        check("R2 rising edge no request", irq_n, 1);
        strobe_fall();
        check("R2 falling edge asserts irq", irq_n, 0);
        check("R3 cathode blanked", cathode, 0);
        check("R3 lit dark", lit, 0);
        cycle(); cycle();
        check("R2 steady low no change", irq_n, 0);
        wr_row(8'h3C);
        check("R8 row write keeps irq", irq_n, 0);
        check("R8 row write keeps cathode dark", cathode, 0);
        wr_col(8'h09);
        check("R5 write releases irq", irq_n, 1);
        check("R4 cathode after ack", cathode, 4'h9);
        check("R9 lit after ack", lit, map(8'h3C, 4'h9));
    endtask

    task automatic t_double();
        strobe_rise();
        strobe_fall();
        strobe_rise();
        strobe_fall();
        check("R6 second edge keeps irq", irq_n, 0);
        wr_col(8'h03);
        check("R6 single ack clears", irq_n, 1);
        cycle(); cycle();
        check("R6 no counted request", irq_n, 1);
        check("R10 cathode held", cathode, 4'h3);
    endtask

    task automatic t_collide();
        strobe_rise();
        line_bit = 1'b0; cath_wr = 1'b1; wr_data = 8'h0F;
        cycle();
        cath_wr = 1'b0;
        check("R7 edge wins irq", irq_n, 0);
        check("R7 edge wins cathode", cathode, 0);
        wr_col(8'h0C);
        check("R5 ack after collision", irq_n, 1);
        check("R4 cathode after collision", cathode, 4'hC);
    endtask

    initial begin
        cycle();
        t_reset();
        t_row_col();
        t_edge_ack();
        t_double();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule